// File: doc/BRIEF.md
# USB Control Endpoint Status Controller

This block keeps the control-transfer state of a USB device's endpoint 0. The serial interface engine reports each decoded token to it as a one-cycle event. SETUP, IN and OUT tokens each arrive with the data PID toggle, the packet length and the CRC result. For every token with a good CRC, the block returns one handshake decision one cycle later: ACK, NAK, STALL, send the loaded data packet, or send a zero-length packet. A single-cycle acknowledge input tells it that the host accepted an IN packet.

Firmware reaches the block through an 8-bit register. The register holds hardware-set status (packet received, protocol error, early termination) and the controls that firmware drives (packet loaded, stall request, last packet of the data stage). The block works out the setup, data and status stages from these controls and from the direction of the first data token.

A protocol violation aborts the transfer and is reported through a sticky error bit. Firmware does the request decoding and moves the packet data. This block only decides the handshakes and keeps the flags.

Top module: `ep0_ctrl_status`

Register layout (bit: name, access):
- bit 0: `rxReady`, read-only.
- bit 1: `txLoaded`, write 1 to set.
- bit 2: `stallReq`, read/write; every write loads it.
- bit 3: `lastPkt`, write 1 to set.
- bit 4: `protoErr`, write 0 to clear.
- bit 5: `earlyEnd`, read-only.
- bit 6: `ackRx`, write-1 action, reads 0.
- bit 7: `ackEarly`, write-1 action, reads 0.

Handshake codes: 0 ACK, 1 NAK, 2 STALL, 3 DATA, 4 ZLP.

Token types: 0 SETUP, 1 IN, 2 OUT.

## Requirements
- R1: After reset the register reads 0x00, `hsValid` is 0, and no transfer is active.
- R2: A SETUP with good CRC is always answered ACK in the next cycle. With DATA0 it also sets `rxReady` (bit 0). A token with a bad CRC gets no handshake and changes no state.
- R3: Writing 1 to bit 6 clears `rxReady`. Bits 6 and 7 always read 0. Writing 0 to bit 0 or bit 5 has no effect.
- R4: Firmware sets `txLoaded` (bit 1). A data-stage IN is then answered DATA (code 3). An `inAck` after that DATA clears `txLoaded`.
- R5: A data-stage OUT while `rxReady` is 1 is answered NAK. A data-stage IN while `txLoaded` is 0 is answered NAK. A data-stage OUT with `rxReady` 0 is answered ACK and sets `rxReady`.
- R6: While `stallReq` (bit 2) is 1, every good IN or OUT token is answered STALL without setting `protoErr`. The bit stays 1 until a write with bit 2 at 0. One write may set it and clear `rxReady` together.
- R7: Once `lastPkt` (bit 3) is 1 and the current data packet has been handled, the next token opposite to the data direction is the status stage. A status IN is answered ZLP and completes on `inAck`. A status OUT with DATA1 is answered ACK and completes at once. Completion clears `lastPkt` and ends the transfer.
- R8: An IN token while no transfer is active is answered STALL and sets `protoErr` (bit 4).
- R9: These conditions set `protoErr`, are answered STALL, end the transfer and clear `lastPkt`: a status OUT with DATA0, a data-direction token in the status stage, and an OUT longer than `MAX_PKT`. A write with bit 4 at 0 clears `protoErr`.
- R10: A SETUP with DATA1 is answered ACK, sets `protoErr` and leaves `rxReady` at 0. The next IN or OUT is answered STALL, and the packet after that starts a new transfer.
- R11: A status-direction token that arrives before `lastPkt` is set sets `earlyEnd` (bit 5), clears `txLoaded` and ends the transfer. Writing 1 to bit 7 clears `earlyEnd`.
- R12: A SETUP that arrives while a transfer is still active sets `earlyEnd`, and it still sets `rxReady`.
- R13: A STALL decision takes priority over NAK and DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | One-cycle token event |
| tokType | input | 2 | 0 SETUP, 1 IN, 2 OUT |
| tokPid1 | input | 1 | Data packet used DATA1 |
| tokLen | input | LEN_W | Data packet length in bytes |
| tokCrcOk | input | 1 | Token and data CRC were good |
| inAck | input | 1 | Host acknowledged the last IN packet |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| hsValid | output | 1 | Handshake decision valid |
| hsCode | output | 3 | Handshake decision code |

## Verification
The checker watches, on every cycle, the rules that need no knowledge of the transfer stage:
- SETUP acceptance and bad-CRC silence.
- Stall-request priority and hold.
- Stickiness of `rxReady`.
- The action bits reading 0.
- `earlyEnd` coinciding with `txLoaded` being dropped.

The stage-dependent behaviour can only be shown by the bench's scenarios:
- status detection from `lastPkt` and the data direction;
- every protocol-error abort;
- the deferred stall after a bad SETUP toggle;
- early termination.

Each of these needs a sequence of tokens and register writes to reach.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_IN    = 2'd1,
    TOK_OUT   = 2'd2
  } tok_e;

  typedef enum logic [2:0] {
    HS_ACK   = 3'd0,
    HS_NAK   = 3'd1,
    HS_STALL = 3'd2,
    HS_DATA  = 3'd3,
    HS_ZLP   = 3'd4
  } hs_e;

  // register bit positions
  localparam int B_RX_READY  = 0;
  localparam int B_TX_LOADED = 1;
  localparam int B_STALL_REQ = 2;
  localparam int B_LAST_PKT  = 3;
  localparam int B_PROTO_ERR = 4;
  localparam int B_EARLY_END = 5;
  localparam int B_ACK_RX    = 6;
  localparam int B_ACK_EARLY = 7;
  localparam int REG_W       = 8;

  // strobes from the phase control to the register datapath
  typedef struct packed {
    logic setRxReady;
    logic clrTxLoaded;
    logic clrLastPkt;
    logic setProtoErr;
    logic setEarlyEnd;
  } hwStrobe_t;

  // register state seen by the phase control
  typedef struct packed {
    logic rxReady;
    logic txLoaded;
    logic stallReq;
    logic lastPkt;
  } csrView_t;

endpackage

// File: rtl/ep0_csr_datapath.sv
module ep0_csr_datapath
  import ep0_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  input  hwStrobe_t        hwStrb,
  output logic [REG_W-1:0] regRdata,
  output csrView_t         csrView
);

  logic rxReady, txLoaded, stallReq, lastPkt, protoErr, earlyEnd;
  logic unusedRoBits;

  // read-only positions carry no write meaning
  assign unusedRoBits = ^{regWdata[B_RX_READY], regWdata[B_EARLY_END]};

  // hardware events win over firmware writes in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReady  <= 1'b0;
      txLoaded <= 1'b0;
      stallReq <= 1'b0;
      lastPkt  <= 1'b0;
      protoErr <= 1'b0;
      earlyEnd <= 1'b0;
    end else begin
      if (hwStrb.setRxReady)
        rxReady <= 1'b1;
      else if (regWr && regWdata[B_ACK_RX])
        rxReady <= 1'b0;

      if (hwStrb.clrTxLoaded || hwStrb.setEarlyEnd)
        txLoaded <= 1'b0;
      else if (regWr && regWdata[B_TX_LOADED])
        txLoaded <= 1'b1;

      if (regWr)
        stallReq <= regWdata[B_STALL_REQ];

      if (hwStrb.clrLastPkt)
        lastPkt <= 1'b0;
      else if (regWr && regWdata[B_LAST_PKT])
        lastPkt <= 1'b1;

      if (hwStrb.setProtoErr)
        protoErr <= 1'b1;
      else if (regWr && !regWdata[B_PROTO_ERR])
        protoErr <= 1'b0;

      if (hwStrb.setEarlyEnd)
        earlyEnd <= 1'b1;
      else if (regWr && regWdata[B_ACK_EARLY])
        earlyEnd <= 1'b0;
    end
  end

  always_comb begin
    regRdata              = '0;
    regRdata[B_RX_READY]  = rxReady;
    regRdata[B_TX_LOADED] = txLoaded;
    regRdata[B_STALL_REQ] = stallReq;
    regRdata[B_LAST_PKT]  = lastPkt;
    regRdata[B_PROTO_ERR] = protoErr;
    regRdata[B_EARLY_END] = earlyEnd;
  end

  assign csrView = '{rxReady: rxReady, txLoaded: txLoaded,
                     stallReq: stallReq, lastPkt: lastPkt};

endmodule

// File: rtl/ep0_phase_ctrl.sv
module ep0_phase_ctrl
  import ep0_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int LEN_W   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokValid,
  input  logic [1:0]       tokType,
  input  logic             tokPid1,
  input  logic [LEN_W-1:0] tokLen,
  input  logic             tokCrcOk,
  input  logic             inAck,
  input  csrView_t         csrView,
  output hwStrobe_t        hwStrb,
  output logic             hsValid,
  output logic [2:0]       hsCode
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PKT);

  logic active, dirKnown, dirIn, pendStall, zlpWait, awaitData;
  logic activeNxt, dirKnownNxt, dirInNxt, pendNxt, zlpNxt, awaitNxt;
  logic hsValidNxt;
  hs_e  hsNxt, hsQ;
  logic statusNow, isIn, tokGood;

  assign tokGood = tokValid && tokCrcOk;
  assign isIn    = (tok_e'(tokType) == TOK_IN);

  // the status stage opens once the last data packet is set and handled
  always_comb begin
    if (!active || !csrView.lastPkt)
      statusNow = 1'b0;
    else if (!dirKnown)
      statusNow = !csrView.rxReady && !csrView.txLoaded;
    else if (dirIn)
      statusNow = !csrView.txLoaded;
    else
      statusNow = !csrView.rxReady;
  end

  always_comb begin
    hwStrb      = '0;
    activeNxt   = active;
    dirKnownNxt = dirKnown;
    dirInNxt    = dirIn;
    pendNxt     = pendStall;
    zlpNxt      = zlpWait;
    awaitNxt    = awaitData;
    hsValidNxt  = 1'b0;
    hsNxt       = HS_ACK;

    if (inAck) begin
      if (zlpWait) begin
        hwStrb.clrLastPkt = 1'b1;
        activeNxt         = 1'b0;
        zlpNxt            = 1'b0;
      end else if (awaitData) begin
        hwStrb.clrTxLoaded = 1'b1;
        awaitNxt           = 1'b0;
      end
    end

    if (tokGood) begin
      hsValidNxt = 1'b1;
      zlpNxt     = 1'b0;
      awaitNxt   = 1'b0;
      if (tok_e'(tokType) == TOK_SETUP) begin
        hsNxt             = HS_ACK;
        hwStrb.clrLastPkt = 1'b1;
        dirKnownNxt       = 1'b0;
        dirInNxt          = 1'b0;
        if (active)
          hwStrb.setEarlyEnd = 1'b1;
        if (tokPid1) begin
          hwStrb.setProtoErr = 1'b1;
          pendNxt            = 1'b1;
          activeNxt          = 1'b0;
        end else begin
          hwStrb.setRxReady = 1'b1;
          pendNxt           = 1'b0;
          activeNxt         = 1'b1;
        end
      end else if (pendStall) begin
        hsNxt   = HS_STALL;
        pendNxt = 1'b0;
      end else if (!active) begin
        hsNxt = HS_STALL;
        if (isIn)
          hwStrb.setProtoErr = 1'b1;
      end else if (csrView.stallReq) begin
        hsNxt = HS_STALL;
      end else if (!isIn && (tokLen > MAX_LEN)) begin
        hsNxt              = HS_STALL;
        hwStrb.setProtoErr = 1'b1;
        hwStrb.clrLastPkt  = 1'b1;
        activeNxt          = 1'b0;
      end else if (statusNow) begin
        if (isIn && !dirIn) begin
          hsNxt  = HS_ZLP;
          zlpNxt = 1'b1;
        end else if (!isIn && dirIn && tokPid1) begin
          hsNxt             = HS_ACK;
          hwStrb.clrLastPkt = 1'b1;
          activeNxt         = 1'b0;
        end else begin
          hsNxt              = HS_STALL;
          hwStrb.setProtoErr = 1'b1;
          hwStrb.clrLastPkt  = 1'b1;
          activeNxt          = 1'b0;
        end
      end else if (dirKnown && (isIn != dirIn)) begin
        hwStrb.setEarlyEnd = 1'b1;
        activeNxt          = 1'b0;
        if (isIn) begin
          hsNxt = HS_ZLP;
        end else if (tokPid1) begin
          hsNxt = HS_ACK;
        end else begin
          hsNxt              = HS_STALL;
          hwStrb.setProtoErr = 1'b1;
        end
      end else begin
        dirKnownNxt = 1'b1;
        dirInNxt    = isIn;
        if (isIn) begin
          if (csrView.txLoaded) begin
            hsNxt    = HS_DATA;
            awaitNxt = 1'b1;
          end else begin
            hsNxt = HS_NAK;
          end
        end else begin
          if (csrView.rxReady) begin
            hsNxt = HS_NAK;
          end else begin
            hsNxt             = HS_ACK;
            hwStrb.setRxReady = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      dirKnown  <= 1'b0;
      dirIn     <= 1'b0;
      pendStall <= 1'b0;
      zlpWait   <= 1'b0;
      awaitData <= 1'b0;
      hsValid   <= 1'b0;
      hsQ       <= HS_ACK;
    end else begin
      active    <= activeNxt;
      dirKnown  <= dirKnownNxt;
      dirIn     <= dirInNxt;
      pendStall <= pendNxt;
      zlpWait   <= zlpNxt;
      awaitData <= awaitNxt;
      hsValid   <= hsValidNxt;
      hsQ       <= hsNxt;
    end
  end

  assign hsCode = hsQ;

endmodule

// File: rtl/ep0_ctrl_status.sv
module ep0_ctrl_status
  import ep0_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int LEN_W   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokValid,
  input  logic [1:0]       tokType,
  input  logic             tokPid1,
  input  logic [LEN_W-1:0] tokLen,
  input  logic             tokCrcOk,
  input  logic             inAck,
  input  logic             regWr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             hsValid,
  output logic [2:0]       hsCode
);

  hwStrobe_t hwStrb;
  csrView_t  csrView;

  ep0_phase_ctrl #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .tokValid(tokValid), .tokType(tokType), .tokPid1(tokPid1),
    .tokLen(tokLen), .tokCrcOk(tokCrcOk), .inAck(inAck),
    .csrView(csrView), .hwStrb(hwStrb),
    .hsValid(hsValid), .hsCode(hsCode)
  );

  ep0_csr_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regWdata(regWdata),
    .hwStrb(hwStrb), .regRdata(regRdata), .csrView(csrView)
  );

endmodule

// File: rtl/ep0_status_checker.sv
module ep0_status_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tokValid,
  input logic [1:0] tokType,
  input logic       tokPid1,
  input logic       tokCrcOk,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       hsValid,
  input logic [2:0] hsCode
);

  p_setup_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    tokValid && tokCrcOk && tokType == 2'd0 |=> hsValid && hsCode == 3'd0);

  p_setup_rx_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    tokValid && tokCrcOk && tokType == 2'd0 && !tokPid1 |=> regRdata[0]);

  p_silent_without_token_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(tokValid && tokCrcOk) |=> !hsValid);

  p_action_bits_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[7:6] == 2'b00);

  p_rx_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[0] && !(regWr && regWdata[6]) |=> regRdata[0]);

  p_stall_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[2] && !regWr |=> regRdata[2]);

  p_stall_over_nak_r13: assert property (@(posedge clk) disable iff (!rstN)
    tokValid && tokCrcOk && tokType != 2'd0 && regRdata[2]
    |=> hsValid && hsCode == 3'd2);

  p_early_drops_tx_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdata[5]) |-> !regRdata[1]);

endmodule

bind ep0_ctrl_status ep0_status_checker u_chk (
  .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokType(tokType),
  .tokPid1(tokPid1), .tokCrcOk(tokCrcOk), .regWr(regWr),
  .regWdata(regWdata), .regRdata(regRdata), .hsValid(hsValid),
  .hsCode(hsCode)
);

// File: tb/test_ep0_ctrl_status.sv
module test_ep0_ctrl_status;

  localparam int MAX_PKT = 64;
  localparam int LEN_W   = 10;
  localparam int ACK = 0, NAK = 1, STALL = 2, DATA = 3, ZLP = 4, NONE = -1;
  localparam int T_SETUP = 0, T_IN = 1, T_OUT = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tokValid = 1'b0;
  logic [1:0]       tokType = '0;
  logic             tokPid1 = 1'b0;
  logic [LEN_W-1:0] tokLen = '0;
  logic             tokCrcOk = 1'b0;
  logic             inAck = 1'b0;
  logic             regWr = 1'b0;
  logic [7:0]       regWdata = '0;
  logic [7:0]       regRdata;
  logic             hsValid;
  logic [2:0]       hsCode;

  int compared = 0;
  int mismatched = 0;
  int lastHs;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ep0_ctrl_status #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) i_ep0_ctrl_status (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokType(tokType),
    .tokPid1(tokPid1), .tokLen(tokLen), .tokCrcOk(tokCrcOk), .inAck(inAck),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .hsValid(hsValid), .hsCode(hsCode)
  );

  function automatic int expOutData(int len);
    return (len > MAX_PKT) ? STALL : ACK;
  endfunction

  function automatic int expUnderStall(bit crc);
    return crc ? STALL : NONE;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendTok(int typ, bit pid1, int len, bit crc);
    @(negedge clk);
    tokValid = 1'b1;
    tokType  = 2'(typ);
    tokPid1  = pid1;
    tokLen   = LEN_W'(len);
    tokCrcOk = crc;
    @(negedge clk);
    tokValid = 1'b0;
    lastHs   = hsValid ? int'(hsCode) : NONE;
  endtask

  task automatic cpuWrite(logic [7:0] d);
    @(negedge clk);
    regWr    = 1'b1;
    regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic hostAck();
    @(negedge clk);
    inAck = 1'b1;
    @(negedge clk);
    inAck = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reg", int'(regRdata), 0);
    check("R1 hsValid", int'(hsValid), 0);

    // IN with no transfer
    sendTok(T_IN, 0, 0, 1);
    check("R8 hs", lastHs, STALL);
    check("R8 reg", int'(regRdata), 8'h10);
    cpuWrite(8'h00);
    check("R9 clear", int'(regRdata), 0);

    // control read
    sendTok(T_SETUP, 0, 8, 1);
    check("R2 hs", lastHs, ACK);
    check("R2 rxReady", int'(regRdata), 8'h01);
    sendTok(T_OUT, 1, 4, 0);
    check("R2 badcrc hs", lastHs, NONE);
    check("R2 badcrc reg", int'(regRdata), 8'h01);
    cpuWrite(8'h21);
    check("R3 write0 no effect", int'(regRdata), 8'h01);
    cpuWrite(8'hC0);
    check("R3 ackRx", int'(regRdata), 8'h00);
    cpuWrite(8'h02);
    sendTok(T_IN, 0, 0, 1);
    check("R4 data", lastHs, DATA);
    hostAck();
    check("R4 txLoaded cleared", int'(regRdata), 0);
    sendTok(T_IN, 0, 0, 1);
    check("R5 in nak", lastHs, NAK);
    cpuWrite(8'h0A);
    sendTok(T_IN, 0, 0, 1);
    check("R4 last data", lastHs, DATA);
    hostAck();
    check("R7 lastPkt held", int'(regRdata), 8'h08);
    sendTok(T_OUT, 1, 0, 1);
    check("R7 status out", lastHs, ACK);
    check("R7 lastPkt cleared", int'(regRdata), 0);

    // control write
    sendTok(T_SETUP, 0, 8, 1);
    cpuWrite(8'h40);
    sendTok(T_OUT, 1, 8, 1);
    check("R5 out ack", lastHs, ACK);
    check("R5 rxReady", int'(regRdata), 8'h01);
    sendTok(T_OUT, 0, 8, 1);
    check("R5 out nak", lastHs, NAK);
    cpuWrite(8'h48);
    check("R7 lastPkt set", int'(regRdata), 8'h08);
    sendTok(T_IN, 0, 0, 1);
    check("R7 status zlp", lastHs, ZLP);
    hostAck();
    check("R7 complete", int'(regRdata), 0);

    // more data after lastPkt
    sendTok(T_SETUP, 0, 8, 1);
    cpuWrite(8'h40);
    sendTok(T_OUT, 1, 8, 1);
    cpuWrite(8'h48);
    sendTok(T_OUT, 0, 8, 1);
    check("R9 extra out", lastHs, STALL);
    check("R9 reg", int'(regRdata), 8'h10);
    cpuWrite(8'h00);

    // oversize OUT
    sendTok(T_SETUP, 0, 8, 1);
    cpuWrite(8'h40);
    sendTok(T_OUT, 0, MAX_PKT + 1, 1);
    check("R9 oversize", lastHs, STALL);
    check("R9 oversize reg", int'(regRdata), 8'h10);
    cpuWrite(8'h00);

    // status OUT with DATA0
    sendTok(T_SETUP, 0, 8, 1);
    cpuWrite(8'h40);
    cpuWrite(8'h0A);
    sendTok(T_IN, 0, 0, 1);
    check("R4 read data", lastHs, DATA);
    hostAck();
    sendTok(T_OUT, 0, 0, 1);
    check("R9 bad status toggle", lastHs, STALL);
    check("R9 bad status reg", int'(regRdata), 8'h10);
    cpuWrite(8'h00);

    // bad SETUP toggle
    sendTok(T_SETUP, 1, 8, 1);
    check("R10 ack", lastHs, ACK);
    check("R10 reg", int'(regRdata), 8'h10);
    cpuWrite(8'h00);
    sendTok(T_OUT, 1, 0, 1);
    check("R10 deferred stall", lastHs, STALL);
    sendTok(T_SETUP, 0, 8, 1);
    check("R10 new transfer", lastHs, ACK);
    cpuWrite(8'h42);
    sendTok(T_IN, 0, 0, 1);
    check("R10 data after", lastHs, DATA);
    check("R10 no error", int'(regRdata[4]), 0);
    hostAck();

    // early status
    cpuWrite(8'h02);
    sendTok(T_OUT, 1, 0, 1);
    check("R11 early hs", lastHs, ACK);
    check("R11 early reg", int'(regRdata), 8'h20);
    cpuWrite(8'h80);
    check("R11 cleared", int'(regRdata), 0);

    // stall request
    sendTok(T_SETUP, 0, 8, 1);
    cpuWrite(8'h44);
    check("R6 combined write", int'(regRdata), 8'h04);
    for (int i = 0; i < 24; i++) begin
      int typ;
      bit crc;
      int len;
      typ = ($urandom % 2 == 0) ? T_IN : T_OUT;
      crc = ($urandom % 4) != 0;
      len = int'($urandom % (MAX_PKT + 16));
      sendTok(typ, 1'($urandom % 2), len, crc);
      check("R6 stall random", lastHs, expUnderStall(crc));
    end
    check("R6 no error", int'(regRdata), 8'h04);
    sendTok(T_SETUP, 0, 8, 1);
    check("R12 reg", int'(regRdata), 8'h25);
    sendTok(T_OUT, 1, 8, 1);
    check("R13 stall over nak", lastHs, STALL);
    cpuWrite(8'hC0);
    check("R6 cleared", int'(regRdata), 0);
    sendTok(T_OUT, 1, MAX_PKT + 3, 1);
    cpuWrite(8'h00);

    // random control writes with random lengths
    for (int t = 0; t < 30; t++) begin
      bit aborted;
      int n;
      aborted = 0;
      sendTok(T_SETUP, 0, 8, 1);
      check("R2 random setup", lastHs, ACK);
      cpuWrite(8'h40);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n && !aborted; k++) begin
        int len;
        len = int'($urandom % (MAX_PKT + 10));
        sendTok(T_OUT, 1, len, 1);
        check("R9 random out", lastHs, expOutData(len));
        if (len > MAX_PKT) begin
          aborted = 1;
          check("R9 random err", int'(regRdata), 8'h10);
          cpuWrite(8'h00);
        end else if (k == n - 1) begin
          cpuWrite(8'h48);
        end else begin
          cpuWrite(8'h40);
        end
      end
      if (!aborted) begin
        sendTok(T_IN, 0, 0, 1);
        check("R7 random zlp", lastHs, ZLP);
        hostAck();
        check("R7 random done", int'(regRdata), 0);
      end
    end

    summary();
  end

endmodule